// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus, placed in front of a 2048 x 8 byte store. A fast system clock oversamples SCL and SDA. The block finds start and stop conditions and decodes a slave address byte. The upper nibble of that byte identifies the device type. The next three bits are the top bits of the array address, and bit 0 chooses read or write. After a write address the master sends a word address byte, then one or more data bytes. Up to sixteen data bytes collect in a page buffer. They reach the array only when the master ends the transfer with a stop. Reads return bytes from the current address and continue through the array for as long as the master acknowledges.

The line is open drain. The block drives only an active-high pull-low enable, and the system outside joins it with the pull-up and the master's drive. A commit starts a self-timed write window, whose length is a parameter in system clocks. During that window the block ignores the bus entirely.

Top module: `eeprom2w_slave`

## Requirements
- R1: SCL and SDA activity before the first start condition is ignored. A full address byte clocked without a preceding start gets no acknowledge.
- R2: The block acts on the line only through `sda_pull_o`. The enable changes only while the synchronised SCL is low. Read bits appear on the line most significant bit first.
- R3: A slave address byte whose bits 7..4 differ from 1010 gets no acknowledge. The block then stays silent until the next start.
- R4: For a write (address byte bit 0 = 0), the block pulls SDA low on the ninth clock after each of these: the slave address byte, the word address byte, and every data byte. The array address is {address byte bits 3..1, word address byte}.
- R5: Data bytes are written to the array only on a stop condition. A start that arrives before the stop discards the pending bytes, and no write window follows.
- R6: After a committing stop, the block neither acknowledges nor drives SDA for WR_CYCLES system clocks. After that it responds again.
- R7: A read (address byte bit 0 = 1) is acknowledged. The block then sends the byte at {bank bits, last word address}. A random read is a word-address write phase, then a repeated start, then a read address byte.
- R8: In a sequential read the full 11-bit address increments after each byte and wraps from 2047 to 0.
- R9: In a page write only the low four address bits advance. Bytes past the sixteenth wrap within the same 16-byte page and overwrite earlier positions.
- R10: If the master does not acknowledge a read byte, the block releases SDA and sends nothing more until a start or stop.
- R11: While reset is active and after it is released, `sda_pull_o` is 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus (wired level) |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Writes are tried as a single byte, as a page that runs two bytes past its end, and as a transfer abandoned with a repeated start. This separates commit-at-stop from commit-per-byte, and page-local wrap from full-address increment. Reads cover a random read, a sequential read across the 2047-to-0 boundary, and a master no-acknowledge followed by idle clocks. These show that address increment and release behaviour are each correct. Framing faults are tried separately: an address byte without a start, a wrong device-type nibble, and an address attempt inside the write window. Each one must give a missing acknowledge, while the same byte in a valid frame gets one.

// File: rtl/eeprom2w_pkg.sv
package eeprom2w_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DEV,
        S_WADDR,
        S_WDATA,
        S_ACK,
        S_READ,
        S_MACK,
        S_BUSY
    } bus_st_t;

    // Decoded bus events, one system clock wide
    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

    function automatic logic dev_match(input logic [7:0] b);
        return b[7:4] == DEV_TYPE;
    endfunction

endpackage

// File: rtl/e2w_sync.sv
module e2w_sync
    import eeprom2w_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev,
    output logic     scl_lvl
);
    logic [1:0] scl_ff, sda_ff;
    logic       scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_q  <= scl_ff[1];
            sda_q  <= sda_ff[1];
        end
    end

    always_comb begin
        ev.rise  = scl_ff[1] & ~scl_q;
        ev.fall  = ~scl_ff[1] & scl_q;
        ev.start = scl_ff[1] & scl_q & sda_q & ~sda_ff[1];
        ev.stop  = scl_ff[1] & scl_q & ~sda_q & sda_ff[1];
        ev.sda   = sda_ff[1];
    end

    assign scl_lvl = scl_ff[1];
endmodule

// File: rtl/e2w_wtimer.sv
module e2w_wtimer #(
    parameter int WR_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy
);
    localparam int CW = $clog2(WR_CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (go && !busy) begin
            busy <= 1'b1;
            cnt  <= CW'(WR_CYCLES - 1);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/e2w_store.sv
module e2w_store #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    input  logic                     buf_we,
    input  logic [PAGE_W-1:0]        buf_idx,
    input  logic [7:0]               buf_data,
    input  logic                     buf_clear,
    input  logic                     commit,
    input  logic [ADDR_W-PAGE_W-1:0] page_base,
    output logic                     mem_we
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << PAGE_W;

    logic [7:0]               mem  [DEPTH];
    logic [7:0]               pbuf [PAGE];
    logic [PAGE-1:0]          pvalid;
    logic                     walking;
    logic [PAGE_W-1:0]        widx;
    logic [ADDR_W-PAGE_W-1:0] cbase;

    assign rd_data = mem[rd_addr];
    assign mem_we  = walking & pvalid[widx];

    always_ff @(posedge clk) begin
        if (mem_we) mem[{cbase, widx}] <= pbuf[widx];
        if (buf_we) pbuf[buf_idx] <= buf_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pvalid  <= '0;
            walking <= 1'b0;
            widx    <= '0;
            cbase   <= '0;
        end else if (commit) begin
            walking <= 1'b1;
            widx    <= '0;
            cbase   <= page_base;
        end else if (walking) begin
            widx <= widx + 1'b1;
            if (widx == {PAGE_W{1'b1}}) begin
                walking <= 1'b0;
                pvalid  <= '0;
            end
        end else if (buf_clear) begin
            pvalid <= '0;
        end else if (buf_we) begin
            pvalid[buf_idx] <= 1'b1;
        end
    end
endmodule

// File: rtl/e2w_busctl.sv
module e2w_busctl
    import eeprom2w_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  line_ev_t                 ev,
    input  logic                     busy,
    input  logic [7:0]               rd_data,
    output logic [ADDR_W-1:0]        rd_addr,
    output logic                     buf_we,
    output logic [PAGE_W-1:0]        buf_idx,
    output logic [7:0]               buf_data,
    output logic                     buf_clear,
    output logic                     commit,
    output logic [ADDR_W-PAGE_W-1:0] page_base,
    output logic                     pull
);
    localparam int BANK_W = ADDR_W - 8;

    bus_st_t           st, ack_nxt;
    logic [3:0]        cnt;
    logic [7:0]        shreg;
    logic [ADDR_W-1:0] addr;
    logic              have_data;
    logic              mack;

    assign commit    = ev.stop && (st == S_WDATA) && have_data;
    assign rd_addr   = addr;
    assign page_base = addr[ADDR_W-1:PAGE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            ack_nxt   <= S_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            addr      <= '0;
            have_data <= 1'b0;
            mack      <= 1'b0;
            pull      <= 1'b0;
            buf_we    <= 1'b0;
            buf_idx   <= '0;
            buf_data  <= '0;
            buf_clear <= 1'b0;
        end else begin
            buf_we    <= 1'b0;
            buf_clear <= 1'b0;
            if (st == S_BUSY) begin
                if (!busy) st <= S_IDLE;
            end else if (ev.stop) begin
                st        <= commit ? S_BUSY : S_IDLE;
                buf_clear <= !commit;
                have_data <= 1'b0;
                pull      <= 1'b0;
            end else if (ev.start) begin
                st        <= S_DEV;
                cnt       <= '0;
                buf_clear <= 1'b1;
                have_data <= 1'b0;
                pull      <= 1'b0;
            end else begin
                case (st)
                    S_DEV, S_WADDR, S_WDATA: begin
                        if (ev.rise && cnt != 4'd8) begin
                            shreg <= {shreg[6:0], ev.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (ev.fall && cnt == 4'd8) begin
                            cnt <= '0;
                            if (st == S_DEV) begin
                                if (dev_match(shreg)) begin
                                    pull    <= 1'b1;
                                    st      <= S_ACK;
                                    addr    <= {shreg[BANK_W:1], addr[7:0]};
                                    ack_nxt <= shreg[0] ? S_READ : S_WADDR;
                                end else begin
                                    st <= S_IDLE;
                                end
                            end else if (st == S_WADDR) begin
                                addr    <= {addr[ADDR_W-1:8], shreg};
                                pull    <= 1'b1;
                                st      <= S_ACK;
                                ack_nxt <= S_WDATA;
                            end else begin
                                buf_we    <= 1'b1;
                                buf_idx   <= addr[PAGE_W-1:0];
                                buf_data  <= shreg;
                                addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
                                have_data <= 1'b1;
                                pull      <= 1'b1;
                                st        <= S_ACK;
                                ack_nxt   <= S_WDATA;
                            end
                        end
                    end
                    S_ACK: if (ev.fall) begin
                        st <= ack_nxt;
                        if (ack_nxt == S_READ) begin
                            pull <= ~rd_data[7];
                            cnt  <= 4'd1;
                        end else begin
                            pull <= 1'b0;
                            cnt  <= '0;
                        end
                    end
                    S_READ: if (ev.fall) begin
                        if (cnt == 4'd8) begin
                            pull <= 1'b0;
                            st   <= S_MACK;
                            addr <= addr + 1'b1;
                        end else begin
                            pull <= ~rd_data[3'd7 - cnt[2:0]];
                            cnt  <= cnt + 1'b1;
                        end
                    end
                    S_MACK: begin
                        if (ev.rise) mack <= ~ev.sda;
                        if (ev.fall) begin
                            if (mack) begin
                                st   <= S_READ;
                                pull <= ~rd_data[7];
                                cnt  <= 4'd1;
                            end else begin
                                st <= S_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/eeprom2w_slave.sv
module eeprom2w_slave
    import eeprom2w_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int PAGE_W    = 4,
    parameter int WR_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);
    localparam int BASE_W = ADDR_W - PAGE_W;

    line_ev_t          ev;
    logic              scl_lvl;
    logic              busy;
    logic              commit;
    logic              buf_we, buf_clear, mem_we;
    logic [PAGE_W-1:0] buf_idx;
    logic [7:0]        buf_data, rd_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [BASE_W-1:0] page_base;

    e2w_sync u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .ev(ev), .scl_lvl(scl_lvl)
    );

    e2w_busctl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctl (
        .clk(clk), .rst(rst), .ev(ev), .busy(busy), .rd_data(rd_data),
        .rd_addr(rd_addr), .buf_we(buf_we), .buf_idx(buf_idx),
        .buf_data(buf_data), .buf_clear(buf_clear), .commit(commit),
        .page_base(page_base), .pull(sda_pull_o)
    );

    e2w_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
        .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_data(buf_data),
        .buf_clear(buf_clear), .commit(commit), .page_base(page_base),
        .mem_we(mem_we)
    );

    e2w_wtimer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .go(commit), .busy(busy)
    );
endmodule

// File: rtl/e2w_checker.sv
module e2w_checker #(
    parameter int WR_CYCLES = 500000
) (
    input logic clk,
    input logic rst,
    input logic scl_lvl,
    input logic pull,
    input logic busy,
    input logic mem_we
);
    logic [31:0] run;

    always_ff @(posedge clk) begin
        if (rst)       run <= '0;
        else if (busy) run <= run + 1'b1;
        else           run <= '0;
    end

    // R2
    r2_pull_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_lvl && $past(scl_lvl)) |-> (pull == $past(pull) || !pull));

    // R6
    r6_quiet_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !pull);

    // R6
    r6_busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run == WR_CYCLES);

    // R5
    r5_commit_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R11
    r11_reset_chk: assert property (@(posedge clk)
        rst |=> !pull);
endmodule

bind eeprom2w_slave e2w_checker #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .pull(sda_pull_o),
    .busy(busy), .mem_we(mem_we)
);

// File: tb/eeprom2w_slave_bench.sv
module eeprom2w_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int WR         = 400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic pull;
    logic sda_line;
    int   checks = 0;
    int   failures = 0;
    logic [7:0] ref_mem [2048];

    assign sda_line = m_sda & ~pull;

    always #(CLK_PERIOD / 2) clk = ~clk;

    eeprom2w_slave #(.WR_CYCLES(WR)) u_eeprom2w_slave (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
        .sda_pull_o(pull)
    );

    task automatic check(input logic ok, input string req,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic half();
        repeat (Q) @(negedge clk);
    endtask

    // one SCL period; model expects pull == e on every clock of the high phase
    task automatic xbit(input logic b, input logic e, input string req,
                        output logic smp);
        half();
        m_sda = b;
        half();
        m_scl = 1'b1;
        smp = 1'b1;
        for (int i = 0; i < 2 * Q; i++) begin
            @(negedge clk);
            check(pull == e, req, pull, e);
            if (i == Q) smp = sda_line;
        end
        m_scl = 1'b0;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; half();
        m_scl = 1'b1; half();
        m_sda = 1'b0; half();
        m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        m_scl = 1'b0; half();
        m_sda = 1'b0; half();
        m_scl = 1'b1; half();
        m_sda = 1'b1; half();
    endtask

    task automatic send_byte(input logic [7:0] v, input logic ack, input string req);
        logic s;
        for (int i = 7; i >= 0; i--) xbit(v[i], 1'b0, req, s);
        xbit(1'b1, ack, req, s);
    endtask

    task automatic recv_byte(input logic [7:0] e, input logic mack, input string req);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            xbit(1'b1, ~e[i], req, s);
            check(s == e[i], "R2", s, e[i]);
        end
        xbit(~mack, 1'b0, "R10", s);
    endtask

    function automatic logic [7:0] devb(input int addr, input logic rd);
        return {4'b1010, 3'(addr >> 8), rd};
    endfunction

    task automatic addr_phase(input int addr, input string req);
        send_byte(devb(addr, 1'b0), 1'b1, req);
        send_byte(8'(addr), 1'b1, req);
    endtask

    // page write of n bytes, data = seed + k; model wraps low four bits
    task automatic write_seq(input int addr, input int n, input int seed, input string req);
        bus_start();
        addr_phase(addr, "R4");
        for (int k = 0; k < n; k++) begin
            send_byte(8'(seed + k), 1'b1, req);
            ref_mem[(addr & 32'h7F0) | ((addr + k) & 32'hF)] = 8'(seed + k);
        end
        bus_stop();
    endtask

    task automatic read_seq(input int addr, input int n, input string req);
        bus_start();
        addr_phase(addr, req);
        bus_start();
        send_byte(devb(addr, 1'b1), 1'b1, "R7");
        for (int k = 0; k < n; k++)
            recv_byte(ref_mem[(addr + k) & 32'h7FF], k < n - 1, req);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(negedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic s;
        repeat (5) @(negedge clk);
        // R11: released during and after reset
        check(pull == 1'b0, "R11", pull, 0);
        rst = 1'b0;
        repeat (10) begin
            @(negedge clk);
            check(pull == 1'b0, "R11", pull, 0);
        end

        // R1: address byte with no start is not acknowledged
        m_scl = 1'b0;
        send_byte(8'hA0, 1'b0, "R1");
        bus_stop();

        // R3: wrong device type, then silence for the rest of the frame
        bus_start();
        send_byte(8'hB0, 1'b0, "R3");
        send_byte(8'h10, 1'b0, "R3");
        bus_stop();

        // R4 single byte write, then R6 lockout inside the window
        write_seq(32'h123, 1, 8'h5A, "R4");
        bus_start();
        send_byte(devb(0, 1'b1), 1'b0, "R6");
        bus_stop();
        repeat (WR) @(negedge clk);
        // R7 random read after window ends (R6 responds again)
        read_seq(32'h123, 1, "R7");
        bus_stop();

        // R5: abandoned write discarded, no busy window follows
        write_seq(32'h200, 1, 8'h11, "R5");
        repeat (WR + 20) @(negedge clk);
        bus_start();
        addr_phase(32'h200, "R5");
        send_byte(8'h99, 1'b1, "R5");
        read_seq(32'h200, 1, "R5");
        bus_stop();

        // R9: 18 bytes from 0x2F8 wrap inside page 0x2F0
        write_seq(32'h2F0, 8, 8'h80, "R9");
        repeat (WR + 20) @(negedge clk);
        write_seq(32'h2F8, 18, 8'h40, "R9");
        repeat (WR + 20) @(negedge clk);
        read_seq(32'h2F0, 16, "R9");
        bus_stop();

        // R8: sequential read crossing 2047 -> 0
        write_seq(32'h7FF, 1, 8'hC3, "R4");
        repeat (WR + 20) @(negedge clk);
        write_seq(32'h000, 1, 8'h3C, "R4");
        repeat (WR + 20) @(negedge clk);
        read_seq(32'h7FF, 2, "R8");
        // R10: after no-acknowledge the block sends nothing
        for (int i = 0; i < 9; i++) xbit(1'b1, 1'b0, "R10", s);
        bus_stop();
        repeat (10) @(negedge clk);
        check(pull == 1'b0, "R10", pull, 0);

        finish_run();
    end
endmodule